// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block sits between the asynchronous parallel bus of a flash device and its internal program/erase engine. It watches the chip-enable, write-enable and output-enable strobes, takes an 8-bit command from the low data byte at the end of every bus write cycle, and tracks which operating mode the device is in. The modes are array read, identify, status read, write armed, erase armed, engine busy and erase suspended.

From the mode it drives one-cycle start, suspend and resume pulses to the engine, with the latched operation address and data. It also drives a selector that tells the read path whether to return array contents, identification bytes or the status byte. It holds the sticky error flags of the status byte. It enforces the two-cycle write and erase sequences, the null-write abort, the lockout while the engine runs, the restricted command set while an erase is suspended, and the refusal to start work while a program-voltage error is pending.

Top module: `flash_cmd_fsm`

## Requirements
- R1: A bus write is taken only when both enables are low and output-enable is high. It is captured once, when the first of chip-enable or write-enable rises. A cycle with output-enable low has no effect. Data bits 15:8 are ignored for commands.
- R2: After reset `mode_o` is 0 (array read), `rd_sel_o` is 0 and `status_o` is 80h. The mode codes are 0 array, 1 identify, 2 status, 3 write armed, 4 erase armed, 5 busy and 6 suspended.
- R3: FFh selects array read, 90h identify and 70h status read, and each mode persists until the next command. `rd_sel_o` is 0 for array, 1 for identify and 2 for status. In identify mode `id_data_o` is the maker code when address bit 0 is low and the device code when it is high.
- R4: Codes outside the command set, and D0h or B0h outside their sequences, leave the mode unchanged.
- R5: 40h or 10h arms a write. The next bus write pulses `prog_start_o` with its address and data on `op_addr_o`/`op_data_o`, sets the mode to busy and clears status bit 7.
- R6: If the armed write carries all-ones data (bits 7:0 = FFh when `byte_mode_i` is 1, all 16 bits set when it is 0), the write is cancelled. The mode returns to array read and no start pulse is issued.
- R7: 20h followed by D0h pulses `erase_start_o` with the confirm cycle's address and sets the mode to busy.
- R8: 20h followed by any other byte starts nothing, sets the mode to status read, and sets status bits 5 and 4.
- R9: While busy, every command is ignored (B0h excepted during an erase) and `rd_sel_o` is 2. `eng_done_i` moves the mode to status read. With `eng_err_i` it sets bit 4 after a program or bit 5 after an erase. With `eng_vpp_i` it sets bit 3.
- R10: B0h during an erase pulses `suspend_o`, sets the mode to suspended and sets status bits 7 and 6. In suspend only FFh (array view), 70h (status view) and D0h are taken. D0h pulses `resume_o`, returns the mode to busy and clears bits 7:6.
- R11: 50h clears status bits 5:3 and leaves the mode unchanged.
- R12: While status bit 3 is set, 40h/10h and an erase confirm start nothing and move the mode to status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Bus chip enable, active low |
| we_ni | input | 1 | Bus write enable, active low |
| oe_ni | input | 1 | Bus output enable, active low |
| addr_i | input | AW | Bus address |
| data_i | input | DW | Bus write data |
| byte_mode_i | input | 1 | 1 = 8-bit bus, 0 = 16-bit bus |
| eng_done_i | input | 1 | Engine finished its operation (pulse) |
| eng_err_i | input | 1 | Operation failed verify, valid with done |
| eng_vpp_i | input | 1 | Program voltage missing, valid with done |
| mode_o | output | 3 | Current mode code |
| rd_sel_o | output | 2 | Read path source: 0 array, 1 ID, 2 status |
| status_o | output | 8 | Status byte |
| id_data_o | output | 8 | Identification byte for the current address |
| prog_start_o | output | 1 | Start program pulse |
| erase_start_o | output | 1 | Start block erase pulse |
| suspend_o | output | 1 | Suspend erase pulse |
| resume_o | output | 1 | Resume erase pulse |
| op_addr_o | output | AW | Address of the started operation |
| op_data_o | output | DW | Data of the started operation |

## Verification
The strobes pass through one input register, so the capture is seen one edge after the enable rises. Mode, status and pulse outputs then change on the second rising edge after the strobe rises. Each bus write task therefore waits two falling edges after releasing the strobes and checks there, while a one-cycle pulse is still high. An engine done pulse acts on the next rising edge and is checked at the following falling edge. The identification byte follows the address through the input register and is sampled two falling edges after the address changes.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  typedef enum logic [2:0] {
    M_ARRAY  = 3'd0,
    M_ID     = 3'd1,
    M_STAT   = 3'd2,
    M_WSETUP = 3'd3,
    M_ESETUP = 3'd4,
    M_BUSY   = 3'd5,
    M_SUSP   = 3'd6
  } mode_e;

  typedef enum logic [3:0] {
    C_READ, C_IDENT, C_STAT, C_CLR, C_ESETUP, C_CONF, C_WSETUP, C_SUSP, C_BAD
  } cmd_e;

  localparam logic [1:0] SEL_ARRAY = 2'd0;
  localparam logic [1:0] SEL_ID    = 2'd1;
  localparam logic [1:0] SEL_STAT  = 2'd2;
endpackage

// File: rtl/fcmd_bus_capture.sv
module fcmd_bus_capture #(
  parameter int AW     = 18,
  parameter int DW     = 16,
  parameter bit IN_REG = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          cap_o,
  output logic [AW-1:0] cap_addr_o,
  output logic [DW-1:0] cap_data_o,
  output logic          rd_a0_o
);
  logic          s_ce, s_we, s_oe;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_data;
  logic          act, act_q;

  generate
    if (IN_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          s_ce   <= 1'b1;
          s_we   <= 1'b1;
          s_oe   <= 1'b1;
          s_addr <= '0;
          s_data <= '0;
        end else begin
          s_ce   <= ce_ni;
          s_we   <= we_ni;
          s_oe   <= oe_ni;
          s_addr <= addr_i;
          s_data <= data_i;
        end
      end
    end else begin : g_pass
      assign s_ce   = ce_ni;
      assign s_we   = we_ni;
      assign s_oe   = oe_ni;
      assign s_addr = addr_i;
      assign s_data = data_i;
    end
  endgenerate

  assign act = !s_ce && !s_we && s_oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= 1'b0;
      cap_addr_o <= '0;
      cap_data_o <= '0;
    end else begin
      act_q <= act;
      if (act) begin
        cap_addr_o <= s_addr;
        cap_data_o <= s_data;
      end
    end
  end

  // first enable to rise ends the cycle
  assign cap_o   = act_q && (s_ce || s_we);
  assign rd_a0_o = s_addr[0];
endmodule

// File: rtl/fcmd_decode.sv
module fcmd_decode
  import fcmd_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_e       cmd_o
);
  always_comb begin
    unique case (code_i)
      8'hFF:        cmd_o = C_READ;
      8'h90:        cmd_o = C_IDENT;
      8'h70:        cmd_o = C_STAT;
      8'h50:        cmd_o = C_CLR;
      8'h20:        cmd_o = C_ESETUP;
      8'hD0:        cmd_o = C_CONF;
      8'h40, 8'h10: cmd_o = C_WSETUP;
      8'hB0:        cmd_o = C_SUSP;
      default:      cmd_o = C_BAD;
    endcase
  end
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       set_es_i,
  input  logic       set_ws_i,
  input  logic       set_vpp_i,
  output logic [2:0] err_o     // {erase, write, vpp}
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o <= '0;
    end else if (clr_i) begin
      err_o <= '0;
    end else begin
      err_o <= err_o | {set_es_i, set_ws_i, set_vpp_i};
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fcmd_pkg::*;
#(
  parameter int         AW     = 18,
  parameter int         DW     = 16,
  parameter bit         IN_REG = 1'b1,
  parameter logic [7:0] MFR_ID = 8'h2C,
  parameter logic [7:0] DEV_ID = 8'h70
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          byte_mode_i,
  input  logic          eng_done_i,
  input  logic          eng_err_i,
  input  logic          eng_vpp_i,
  output logic [2:0]    mode_o,
  output logic [1:0]    rd_sel_o,
  output logic [7:0]    status_o,
  output logic [7:0]    id_data_o,
  output logic          prog_start_o,
  output logic          erase_start_o,
  output logic          suspend_o,
  output logic          resume_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_data_o
);
  localparam int BW = 8;

  logic          cap;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;
  logic          rd_a0;
  cmd_e          cmd;
  logic [2:0]    err;
  logic          is_null;

  mode_e         mode_q, mode_d;
  logic          erase_op_q, erase_op_d;
  logic          susp_arr_q, susp_arr_d;
  logic          prog_d, erase_d, susp_d, res_d;
  logic [AW-1:0] op_addr_d;
  logic [DW-1:0] op_data_d;
  logic          clr, set_es, set_ws, set_vpp;

  fcmd_bus_capture #(.AW(AW), .DW(DW), .IN_REG(IN_REG)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_ni      (ce_ni),
    .we_ni      (we_ni),
    .oe_ni      (oe_ni),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .cap_o      (cap),
    .cap_addr_o (cap_addr),
    .cap_data_o (cap_data),
    .rd_a0_o    (rd_a0)
  );

  fcmd_decode u_dec (
    .code_i (cap_data[BW-1:0]),
    .cmd_o  (cmd)
  );

  fcmd_status u_sts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .set_es_i  (set_es),
    .set_ws_i  (set_ws),
    .set_vpp_i (set_vpp),
    .err_o     (err)
  );

  assign is_null = byte_mode_i ? (cap_data[BW-1:0] == {BW{1'b1}}) : (&cap_data);

  always_comb begin
    mode_d     = mode_q;
    erase_op_d = erase_op_q;
    susp_arr_d = susp_arr_q;
    prog_d     = 1'b0;
    erase_d    = 1'b0;
    susp_d     = 1'b0;
    res_d      = 1'b0;
    op_addr_d  = op_addr_o;
    op_data_d  = op_data_o;
    clr        = 1'b0;
    set_es     = 1'b0;
    set_ws     = 1'b0;
    set_vpp    = 1'b0;
    if (mode_q == M_BUSY && eng_done_i) begin
      mode_d  = M_STAT;
      set_es  = eng_err_i && erase_op_q;
      set_ws  = eng_err_i && !erase_op_q;
      set_vpp = eng_vpp_i;
    end else if (cap) begin
      unique case (mode_q)
        M_ARRAY, M_ID, M_STAT: begin
          unique case (cmd)
            C_READ:   mode_d = M_ARRAY;
            C_IDENT:  mode_d = M_ID;
            C_STAT:   mode_d = M_STAT;
            C_CLR:    clr = 1'b1;
            C_ESETUP: mode_d = M_ESETUP;
            C_WSETUP: mode_d = err[0] ? M_STAT : M_WSETUP;
            default:  ;
          endcase
        end
        M_WSETUP: begin
          if (is_null) begin
            mode_d = M_ARRAY;
          end else begin
            mode_d     = M_BUSY;
            erase_op_d = 1'b0;
            prog_d     = 1'b1;
            op_addr_d  = cap_addr;
            op_data_d  = cap_data;
          end
        end
        M_ESETUP: begin
          if (cmd != C_CONF) begin
            mode_d = M_STAT;
            set_es = 1'b1;
            set_ws = 1'b1;
          end else if (err[0]) begin
            mode_d = M_STAT;
          end else begin
            mode_d     = M_BUSY;
            erase_op_d = 1'b1;
            erase_d    = 1'b1;
            op_addr_d  = cap_addr;
          end
        end
        M_BUSY: begin
          if (erase_op_q && cmd == C_SUSP) begin
            mode_d     = M_SUSP;
            susp_arr_d = 1'b0;
            susp_d     = 1'b1;
          end
        end
        M_SUSP: begin
          unique case (cmd)
            C_READ: susp_arr_d = 1'b1;
            C_STAT: susp_arr_d = 1'b0;
            C_CONF: begin
              mode_d = M_BUSY;
              res_d  = 1'b1;
            end
            default: ;
          endcase
        end
        default: mode_d = M_ARRAY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q        <= M_ARRAY;
      erase_op_q    <= 1'b0;
      susp_arr_q    <= 1'b0;
      prog_start_o  <= 1'b0;
      erase_start_o <= 1'b0;
      suspend_o     <= 1'b0;
      resume_o      <= 1'b0;
      op_addr_o     <= '0;
      op_data_o     <= '0;
    end else begin
      mode_q        <= mode_d;
      erase_op_q    <= erase_op_d;
      susp_arr_q    <= susp_arr_d;
      prog_start_o  <= prog_d;
      erase_start_o <= erase_d;
      suspend_o     <= susp_d;
      resume_o      <= res_d;
      op_addr_o     <= op_addr_d;
      op_data_o     <= op_data_d;
    end
  end

  always_comb begin
    unique case (mode_q)
      M_ARRAY: rd_sel_o = SEL_ARRAY;
      M_ID:    rd_sel_o = SEL_ID;
      M_SUSP:  rd_sel_o = susp_arr_q ? SEL_ARRAY : SEL_STAT;
      default: rd_sel_o = SEL_STAT;
    endcase
  end

  assign mode_o    = mode_q;
  assign status_o  = {mode_q != M_BUSY, mode_q == M_SUSP, err, 3'b000};
  assign id_data_o = rd_a0 ? DEV_ID : MFR_ID;
endmodule

// File: rtl/fcmd_checker.sv
module fcmd_checker
  import fcmd_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       eng_done_i,
  input logic [2:0] mode_o,
  input logic [7:0] status_o,
  input logic       prog_start_o,
  input logic       erase_start_o,
  input logic       suspend_o,
  input logic       resume_o
);
  assert_mode_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd6);

  assert_pulse_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_start_o, erase_start_o, suspend_o, resume_o}));

  assert_prog_from_armed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> ($past(mode_o) == M_WSETUP && mode_o == M_BUSY && !status_o[7]));

  assert_erase_from_armed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_start_o |-> ($past(mode_o) == M_ESETUP && mode_o == M_BUSY));

  assert_no_start_vpp_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_start_o || erase_start_o) |-> !$past(status_o[3]));

  assert_busy_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_BUSY && !eng_done_i) |=> (mode_o == M_BUSY || mode_o == M_SUSP));

  assert_done_to_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == M_BUSY && eng_done_i) |=> mode_o == M_STAT);

  assert_suspend_entry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> ($past(mode_o) == M_BUSY && mode_o == M_SUSP && status_o[7:6] == 2'b11));

  assert_resume_entry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> ($past(mode_o) == M_SUSP && mode_o == M_BUSY));
endmodule

bind flash_cmd_fsm fcmd_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .eng_done_i    (eng_done_i),
  .mode_o        (mode_o),
  .status_o      (status_o),
  .prog_start_o  (prog_start_o),
  .erase_start_o (erase_start_o),
  .suspend_o     (suspend_o),
  .resume_o      (resume_o)
);

// File: tb/sim_flash_cmd_fsm.sv
`timescale 1ns/1ps
module sim_flash_cmd_fsm;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam logic [7:0] MFR = 8'h2C;
  localparam logic [7:0] DEV = 8'h70;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic byte_mode = 1'b0;
  logic done = 1'b0, err = 1'b0, vpp = 1'b0;
  logic [2:0] mode;
  logic [1:0] rd_sel;
  logic [7:0] status, id_data;
  logic prog_start, erase_start, susp, res;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  flash_cmd_fsm #(.AW(AW), .DW(DW), .MFR_ID(MFR), .DEV_ID(DEV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(data), .byte_mode_i(byte_mode),
    .eng_done_i(done), .eng_err_i(err), .eng_vpp_i(vpp),
    .mode_o(mode), .rd_sel_o(rd_sel), .status_o(status), .id_data_o(id_data),
    .prog_start_o(prog_start), .erase_start_o(erase_start),
    .suspend_o(susp), .resume_o(res), .op_addr_o(op_addr), .op_data_o(op_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // WE-controlled bus write; returns where results are due
  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; data = d;
    @(negedge clk); @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic eng_finish(input logic e, input logic v);
    @(negedge clk); done = 1'b1; err = e; vpp = v;
    @(negedge clk); done = 1'b0; err = 1'b0; vpp = 1'b0;
  endtask

  task automatic set_addr(input logic [AW-1:0] a);
    @(negedge clk); addr = a;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    check("R2 mode", 32'(mode), 0);
    check("R2 rd_sel", 32'(rd_sel), 0);
    check("R2 status", 32'(status), 32'h80);
    check("R2 pulses", {prog_start, erase_start, susp, res}, 0);
  endtask

  task automatic t_capture;
    // oe low: no capture
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; data = 16'h0090;
    @(negedge clk); @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 oe low ignored", 32'(mode), 0);
    // CE-controlled: ce rises first, we later
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; data = 16'h0090;
    @(negedge clk); @(negedge clk); ce_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 ce rise captures", 32'(mode), 1);
    data = 16'h0070; we_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 late we rise no capture", 32'(mode), 1);
    bus_wr('0, 16'hAB70);
    check("R1 upper byte ignored", 32'(mode), 2);
  endtask

  task automatic t_modes;
    bus_wr('0, 16'h0090);
    check("R3 identify mode", 32'(mode), 1);
    check("R3 identify sel", 32'(rd_sel), 1);
    set_addr(18'h00100);
    check("R3 maker id", 32'(id_data), 32'(MFR));
    set_addr(18'h00101);
    check("R3 device id", 32'(id_data), 32'(DEV));
    bus_wr('0, 16'h0070);
    check("R3 status sel", 32'(rd_sel), 2);
    bus_wr('0, 16'h00FF);
    check("R3 array mode", 32'(mode), 0);
    check("R3 array sel", 32'(rd_sel), 0);
  endtask

  task automatic t_invalid;
    bus_wr('0, 16'h0090);
    bus_wr('0, 16'h0000);
    check("R4 code 00 ignored", 32'(mode), 1);
    bus_wr('0, 16'h00D0);
    check("R4 lone D0 ignored", {29'd0, mode}, 1);
    bus_wr('0, 16'h00B0);
    check("R4 lone B0 ignored", 32'(mode), 1);
    check("R4 no pulses", {prog_start, erase_start, susp, res}, 0);
  endtask

  task automatic t_write;
    bus_wr('0, 16'h0040);
    check("R5 armed", 32'(mode), 3);
    bus_wr(18'h00123, 16'h5A5A);
    check("R5 prog pulse", 32'(prog_start), 1);
    check("R5 op addr", 32'(op_addr), 32'h123);
    check("R5 op data", 32'(op_data), 32'h5A5A);
    check("R5 busy", 32'(mode), 5);
    check("R5 sr7 low", 32'(status[7]), 0);
    bus_wr('0, 16'h00FF);
    check("R9 ignored while busy", 32'(mode), 5);
    check("R9 read shows status", 32'(rd_sel), 2);
    bus_wr('0, 16'h00B0);
    check("R9 B0 ignored in program", 32'(mode), 5);
    eng_finish(1'b0, 1'b0);
    check("R9 done to status", 32'(mode), 2);
    check("R9 status clean", 32'(status), 32'h80);
    bus_wr('0, 16'h0010);
    bus_wr(18'h00200, 16'h1234);
    check("R5 alias 10h starts", 32'(prog_start), 1);
    eng_finish(1'b1, 1'b0);
    check("R9 write error bit", 32'(status), 32'h90);
    bus_wr('0, 16'h0050);
    check("R11 clear", 32'(status), 32'h80);
    check("R11 mode kept", 32'(mode), 2);
  endtask

  task automatic t_null;
    byte_mode = 1'b1;
    bus_wr('0, 16'h0040);
    bus_wr(18'h00010, 16'h00FF);
    check("R6 byte null no start", 32'(prog_start), 0);
    check("R6 byte null to array", 32'(mode), 0);
    byte_mode = 1'b0;
    bus_wr('0, 16'h0040);
    bus_wr(18'h00010, 16'h00FF);
    check("R6 word 00FF not null", 32'(prog_start), 1);
    eng_finish(1'b0, 1'b0);
    bus_wr('0, 16'h0040);
    bus_wr(18'h00010, 16'hFFFF);
    check("R6 word null no start", 32'(prog_start), 0);
    check("R6 word null to array", 32'(mode), 0);
  endtask

  task automatic t_erase_suspend;
    bus_wr('0, 16'h0020);
    check("R7 erase armed", 32'(mode), 4);
    bus_wr(18'h30000, 16'h00D0);
    check("R7 erase pulse", 32'(erase_start), 1);
    check("R7 erase addr", 32'(op_addr), 32'h30000);
    check("R7 busy", 32'(mode), 5);
    bus_wr('0, 16'h00B0);
    check("R10 suspend pulse", 32'(susp), 1);
    check("R10 suspended", 32'(mode), 6);
    check("R10 status", 32'(status), 32'hC0);
    bus_wr('0, 16'h0090);
    check("R10 identify refused", 32'(mode), 6);
    bus_wr('0, 16'h00FF);
    check("R10 array view", 32'(rd_sel), 0);
    bus_wr('0, 16'h0070);
    check("R10 status view", 32'(rd_sel), 2);
    bus_wr('0, 16'h00D0);
    check("R10 resume pulse", 32'(res), 1);
    check("R10 resumed busy", 32'(mode), 5);
    check("R10 sr7 sr6 clear", 32'(status[7:6]), 0);
    eng_finish(1'b1, 1'b1);
    check("R9 erase and vpp bits", 32'(status), 32'hA8);
  endtask

  task automatic t_vpp;
    bus_wr('0, 16'h0040);
    check("R12 write setup refused", 32'(mode), 2);
    bus_wr('0, 16'h0020);
    bus_wr(18'h10000, 16'h00D0);
    check("R12 confirm no start", 32'(erase_start), 0);
    check("R12 confirm to status", 32'(mode), 2);
    bus_wr('0, 16'h0050);
    check("R11 clear all", 32'(status), 32'h80);
  endtask

  task automatic t_bad_erase;
    bus_wr('0, 16'h0020);
    bus_wr('0, 16'h0070);
    check("R8 no erase", 32'(erase_start), 0);
    check("R8 status mode", 32'(mode), 2);
    check("R8 both error bits", 32'(status), 32'hB0);
    bus_wr('0, 16'h0050);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_capture();
    t_modes();
    t_invalid();
    bus_wr('0, 16'h00FF);
    t_write();
    t_null();
    t_erase_suspend();
    t_vpp();
    t_bad_erase();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule